// File: doc/BRIEF.md
# Multicycle Control Sequencer with Trap States

This block is the control unit of a multicycle processor core. Each instruction takes several clock cycles. In each cycle the block drives the enables and selects that a shared datapath needs. The datapath is an instruction register, A and B operand latches, an ALU, a memory port, a register file and a PC. The sequencer handles six operations: load word, store word, register-register arithmetic, OR with an immediate, branch if equal, and jump.

It takes three inputs from the datapath:
- the opcode field of the instruction register;
- the ALU signed-overflow flag;
- the ALU zero-result (equal) flag.

It has two trap states. An opcode outside the supported six leads from decode into a reserved-instruction trap. A signed overflow during register-register execution leads into an overflow trap in place of writeback. Both trap states do four things in the same cycle: they write the exception PC (datapath value PC-4), redirect the PC to the exception vector, record a cause code, and then return to fetch.

All control outputs are registered. Each output is decoded from the next state and captured at the same clock edge as the state register. The datapath therefore sees glitch-free enables directly from flops.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, the outputs show the fetch state: `ir_wr`=1, `mem_rd`=1, `pc_sel`=5'b00010, and `mem_wr`, `reg_wr`, `epc_wr` and `cause_wr` all 0. This also holds when reset arrives in the middle of an instruction.
- R2: Fetch lasts one cycle. It loads the instruction register and selects PC+4. Decode lasts one cycle with `ir_wr`=0 and `pc_sel`=5'b00001 (hold). Dispatch uses these opcodes: register-register 6'h00, load 6'h23, store 6'h2B, branch-equal 6'h04, jump 6'h02, OR-immediate 6'h0D.
- R3: A register-register instruction without overflow takes 4 cycles. Execute uses `alu_src`=0 (register B) and `alu_op`=3 (function field). The next state writes the ALU result to register rd (`reg_dst_rd`=1, `wb_mem`=0).
- R4: Overflow seen in the register-register execute state leads to a trap state in place of writeback. The trap state has `reg_wr`=0, `epc_wr`=1, `cause_wr`=1, `cause_code`=12 and `pc_sel`=5'b10000 (vector). The next state is fetch, so the instruction takes 4 cycles and leaves rd unchanged.
- R5: An opcode other than the six in R2 leads from decode to a trap state with `epc_wr`=1, `cause_wr`=1, `cause_code`=10 and `pc_sel`=5'b10000. Fetch follows, for a total of 3 cycles.
- R6: OR-immediate takes 4 cycles. Execute uses `alu_src`=2 (zero-extended immediate) and `alu_op`=2 (OR). Writeback goes to rt from the ALU.
- R7: Load takes 5 cycles. The address is computed with `alu_src`=1 (sign-extended immediate) and `alu_op`=0 (add). A memory read follows. Writeback goes to rt from memory data (`wb_mem`=1).
- R8: Store takes 4 cycles. It computes the same sign-extended address and then asserts `mem_wr`, with no register write.
- R9: Branch-equal compares A-B (`alu_src`=0, `alu_op`=1). If `alu_eq` is high, the next state selects `pc_sel`=5'b00100 (PC plus sign-extended offset shifted left by 2), for 4 cycles. Otherwise fetch follows directly, for 3 cycles.
- R10: Jump takes 3 cycles. Its third cycle selects `pc_sel`=5'b01000: the PC becomes {PC[31:28], target field, 2'b00}.
- R11: `alu_ovf` is ignored in every state except register-register execute. `alu_eq` is ignored in every state except the branch compare.
- R12: Every cycle, exactly one bit of `pc_sel` is set (bit 0 hold, 1 increment, 2 branch, 3 jump, 4 vector). `epc_wr` and `cause_wr` are asserted together, and only in the two trap states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| alu_eq | input | 1 | ALU result-is-zero flag |
| ir_wr | output | 1 | Load instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| reg_wr | output | 1 | Register file write enable |
| reg_dst_rd | output | 1 | Destination is rd (1) or rt (0) |
| wb_mem | output | 1 | Writeback data from memory (1) or ALU (0) |
| alu_src | output | 2 | ALU B operand: 0 register, 1 sign-ext imm, 2 zero-ext imm |
| alu_op | output | 2 | ALU operation: 0 add, 1 sub, 2 or, 3 function field |
| pc_sel | output | 5 | One-hot PC source: hold, +4, branch, jump, vector |
| epc_wr | output | 1 | Write exception PC |
| cause_wr | output | 1 | Write cause register |
| cause_code | output | 5 | Cause value to record |

## Verification
The bench builds the block with its default cause codes, 10 and 12. It wraps the block in a behavioural datapath, so each instruction's architectural result appears in registers, memory, PC, exception PC and cause.

The defaults make both trap paths checkable as complete instruction sequences. Overflow is driven by real operand pairs, in both add and subtract directions. The datapath raises overflow during address arithmetic and during branch compares as well, so R11 shows up as loads and branches that finish normally. Sentinel values in the untouched registers, the exception PC and the cause register expose any write that should not have happened.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W   = 6;
  localparam int CAUSE_W = 5;
  localparam int PCS_N   = 5;
  localparam int NUM_OPS = 6;

  // opcode values for the supported operations
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW    = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;

  // bit positions inside the one-hot PC source select
  localparam int PCS_HOLD = 0;
  localparam int PCS_INC  = 1;
  localparam int PCS_BR   = 2;
  localparam int PCS_JMP  = 3;
  localparam int PCS_VEC  = 4;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE,
    S_MADDR, S_MREAD, S_LDWB, S_MWRITE,
    S_REXEC, S_RWB,
    S_ORIEXEC, S_ORIWB,
    S_BRCMP, S_BRTAKE,
    S_JUMP,
    S_EXC_RI, S_EXC_OVF
  } state_t;

  typedef enum logic [2:0] {
    C_RTYPE, C_LW, C_SW, C_BEQ, C_JMP, C_ORI, C_ILLEGAL
  } opclass_t;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_SEXT = 2'd1,
    SRC_ZEXT = 2'd2
  } alusrc_t;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_OR   = 2'd2,
    OP_FUNC = 2'd3
  } aluop_t;

  typedef struct packed {
    logic               ir_wr;
    logic               mem_rd;
    logic               mem_wr;
    logic               reg_wr;
    logic               reg_dst_rd;
    logic               wb_mem;
    alusrc_t            alu_src;
    aluop_t             alu_op;
    logic [PCS_N-1:0]   pc_sel;
    logic               epc_wr;
    logic               cause_wr;
    logic [CAUSE_W-1:0] cause_code;
  } ctrl_t;

endpackage

// File: rtl/mcc_op_class.sv
module mcc_op_class
  import mcc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opclass_t         cls
);

  localparam logic [OPC_W-1:0] CODES [NUM_OPS] =
    '{OPC_RTYPE, OPC_LW, OPC_SW, OPC_BEQ, OPC_JMP, OPC_ORI};
  localparam opclass_t CLASSES [NUM_OPS] =
    '{C_RTYPE, C_LW, C_SW, C_BEQ, C_JMP, C_ORI};

  logic [NUM_OPS-1:0] hit;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_match
    assign hit[g] = (opcode == CODES[g]);
  end

  // codes are distinct, so at most one hit is set
  always_comb begin
    cls = C_ILLEGAL;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (hit[k]) cls = CLASSES[k];
    end
  end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_t   cur,
  input  opclass_t cls,
  input  logic     alu_ovf,
  input  logic     alu_eq,
  output state_t   nxt
);

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (cls)
          C_RTYPE:     nxt = S_REXEC;
          C_LW, C_SW:  nxt = S_MADDR;
          C_ORI:       nxt = S_ORIEXEC;
          C_BEQ:       nxt = S_BRCMP;
          C_JMP:       nxt = S_JUMP;
          default:     nxt = S_EXC_RI;
        endcase
      end
      S_MADDR:   nxt = (cls == C_LW) ? S_MREAD : S_MWRITE;
      S_MREAD:   nxt = S_LDWB;
      S_REXEC:   nxt = alu_ovf ? S_EXC_OVF : S_RWB;
      S_ORIEXEC: nxt = S_ORIWB;
      S_BRCMP:   nxt = alu_eq ? S_BRTAKE : S_FETCH;
      default:   nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] RI_CODE  = 5'd10,
  parameter logic [CAUSE_W-1:0] OVF_CODE = 5'd12
) (
  input  state_t st,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl                  = '0;
    ctrl.alu_src          = SRC_REG;
    ctrl.alu_op           = OP_ADD;
    ctrl.pc_sel           = '0;
    ctrl.pc_sel[PCS_HOLD] = 1'b1;
    case (st)
      S_FETCH: begin
        ctrl.ir_wr            = 1'b1;
        ctrl.mem_rd           = 1'b1;
        ctrl.pc_sel           = '0;
        ctrl.pc_sel[PCS_INC]  = 1'b1;
      end
      S_MADDR: begin
        ctrl.alu_src = SRC_SEXT;
        ctrl.alu_op  = OP_ADD;
      end
      S_MREAD:  ctrl.mem_rd = 1'b1;
      S_LDWB: begin
        ctrl.reg_wr = 1'b1;
        ctrl.wb_mem = 1'b1;
      end
      S_MWRITE: ctrl.mem_wr = 1'b1;
      S_REXEC: begin
        ctrl.alu_src = SRC_REG;
        ctrl.alu_op  = OP_FUNC;
      end
      S_RWB: begin
        ctrl.reg_wr     = 1'b1;
        ctrl.reg_dst_rd = 1'b1;
      end
      S_ORIEXEC: begin
        ctrl.alu_src = SRC_ZEXT;
        ctrl.alu_op  = OP_OR;
      end
      S_ORIWB:  ctrl.reg_wr = 1'b1;
      S_BRCMP: begin
        ctrl.alu_src = SRC_REG;
        ctrl.alu_op  = OP_SUB;
      end
      S_BRTAKE: begin
        ctrl.pc_sel          = '0;
        ctrl.pc_sel[PCS_BR]  = 1'b1;
      end
      S_JUMP: begin
        ctrl.pc_sel          = '0;
        ctrl.pc_sel[PCS_JMP] = 1'b1;
      end
      S_EXC_RI, S_EXC_OVF: begin
        ctrl.epc_wr          = 1'b1;
        ctrl.cause_wr        = 1'b1;
        ctrl.cause_code      = (st == S_EXC_RI) ? RI_CODE : OVF_CODE;
        ctrl.pc_sel          = '0;
        ctrl.pc_sel[PCS_VEC] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] RI_CODE  = 5'd10,
  parameter logic [CAUSE_W-1:0] OVF_CODE = 5'd12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               alu_ovf,
  input  logic               alu_eq,
  output logic               ir_wr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               reg_wr,
  output logic               reg_dst_rd,
  output logic               wb_mem,
  output logic [1:0]         alu_src,
  output logic [1:0]         alu_op,
  output logic [PCS_N-1:0]   pc_sel,
  output logic               epc_wr,
  output logic               cause_wr,
  output logic [CAUSE_W-1:0] cause_code
);

  opclass_t cls;
  state_t   state_q, state_d, st_sel;
  ctrl_t    ctrl_d, ctrl_q;

  mcc_op_class u_cls (
    .opcode (opcode),
    .cls    (cls)
  );

  mcc_next_state u_ns (
    .cur     (state_q),
    .cls     (cls),
    .alu_ovf (alu_ovf),
    .alu_eq  (alu_eq),
    .nxt     (state_d)
  );

  // reset folds into the next-state choice so outputs stay registered
  assign st_sel = rst ? S_FETCH : state_d;

  mcc_ctrl_decode #(
    .RI_CODE  (RI_CODE),
    .OVF_CODE (OVF_CODE)
  ) u_dec (
    .st   (st_sel),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= st_sel;
    ctrl_q  <= ctrl_d;
  end

  assign ir_wr      = ctrl_q.ir_wr;
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign reg_wr     = ctrl_q.reg_wr;
  assign reg_dst_rd = ctrl_q.reg_dst_rd;
  assign wb_mem     = ctrl_q.wb_mem;
  assign alu_src    = ctrl_q.alu_src;
  assign alu_op     = ctrl_q.alu_op;
  assign pc_sel     = ctrl_q.pc_sel;
  assign epc_wr     = ctrl_q.epc_wr;
  assign cause_wr   = ctrl_q.cause_wr;
  assign cause_code = ctrl_q.cause_code;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk
  import mcc_pkg::*;
#(
  parameter logic [CAUSE_W-1:0] RI_CODE  = 5'd10,
  parameter logic [CAUSE_W-1:0] OVF_CODE = 5'd12
) (
  input logic               clk,
  input logic               rst,
  input logic [OPC_W-1:0]   opcode,
  input logic               alu_ovf,
  input logic               alu_eq,
  input state_t             state_q,
  input logic               ir_wr,
  input logic               mem_wr,
  input logic               reg_wr,
  input logic               reg_dst_rd,
  input logic               wb_mem,
  input logic [PCS_N-1:0]   pc_sel,
  input logic               epc_wr,
  input logic               cause_wr,
  input logic [CAUSE_W-1:0] cause_code
);

  logic legal;
  assign legal = (opcode == OPC_RTYPE) || (opcode == OPC_LW) ||
                 (opcode == OPC_SW) || (opcode == OPC_BEQ) ||
                 (opcode == OPC_JMP) || (opcode == OPC_ORI);

  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!ir_wr && pc_sel[PCS_HOLD] && state_q == S_DECODE));

  p_rtype_wb_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REXEC && !alu_ovf) |=> (reg_wr && reg_dst_rd && !wb_mem));

  p_ovf_trap_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REXEC && alu_ovf) |=>
      (epc_wr && cause_wr && cause_code == OVF_CODE && !reg_wr));

  p_trap_return_r4: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> ir_wr);

  p_illegal_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && !legal) |=> (cause_wr && cause_code == RI_CODE));

  p_store_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!reg_wr && pc_sel[PCS_HOLD]));

  p_br_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BRCMP && alu_eq) |=> pc_sel[PCS_BR]);

  p_br_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BRCMP && !alu_eq) |=> ir_wr);

  p_ovf_source_r11: assert property (@(posedge clk) disable iff (rst)
    (cause_wr && cause_code == OVF_CODE) |-> $past(state_q == S_REXEC && alu_ovf));

  p_one_pcsel_r12: assert property (@(posedge clk) disable iff (rst)
    $countones(pc_sel) == 1);

  p_trap_pair_r12: assert property (@(posedge clk) disable iff (rst)
    (epc_wr || cause_wr) |-> (epc_wr && cause_wr && pc_sel[PCS_VEC]));

endmodule

bind mcc_ctrl mcc_ctrl_chk #(
  .RI_CODE  (RI_CODE),
  .OVF_CODE (OVF_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .alu_ovf    (alu_ovf),
  .alu_eq     (alu_eq),
  .state_q    (state_q),
  .ir_wr      (ir_wr),
  .mem_wr     (mem_wr),
  .reg_wr     (reg_wr),
  .reg_dst_rd (reg_dst_rd),
  .wb_mem     (wb_mem),
  .pc_sel     (pc_sel),
  .epc_wr     (epc_wr),
  .cause_wr   (cause_wr),
  .cause_code (cause_code)
);

// File: tb/sim_mcc_ctrl.sv
`timescale 1ns/1ps
module sim_mcc_ctrl;

  localparam logic [31:0] EXC_VEC  = 32'h8000_0080;
  localparam logic [31:0] EPC_SENT = 32'h5A5A_5A5A;
  localparam logic [4:0]  CAU_SENT = 5'h1F;
  localparam int          NV       = 18;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] a_val;   // preload of r1 (rs)
    logic [31:0] b_val;   // preload of r2 (rt)
    logic [3:0]  cyc;     // expected cycles until next fetch
    logic        on_mem;  // 1: check memory word, 0: check register
    logic [5:0]  idx;     // register or word index; register 0 skips
    logic [31:0] val;
    logic [31:0] pc;
    logic        exc;
    logic [4:0]  cause;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h00221820, 32'd5,        32'd7,        4'd4, 1'b0, 6'd3, 32'd12,       32'd4,     1'b0, 5'd0 },  // R3 add
    '{32'h00221822, 32'h80000000, 32'd1,        4'd4, 1'b0, 6'd3, 32'h0BAD0003, EXC_VEC,   1'b1, 5'd12},  // R4 sub ovf
    '{32'h00221820, 32'h7FFFFFFF, 32'd1,        4'd4, 1'b0, 6'd3, 32'h0BAD0003, EXC_VEC,   1'b1, 5'd12},  // R4 add ovf
    '{32'h00221825, 32'h80000000, 32'h7FFFFFFF, 4'd4, 1'b0, 6'd3, 32'hFFFFFFFF, 32'd4,     1'b0, 5'd0 },  // R3 or
    '{32'h00221822, 32'd5,        32'd5,        4'd4, 1'b0, 6'd3, 32'd0,        32'd4,     1'b0, 5'd0 },  // R11 zero result
    '{32'h3422F0F0, 32'h00010001, 32'd0,        4'd4, 1'b0, 6'd2, 32'h0001F0F1, 32'd4,     1'b0, 5'd0 },  // R6 ori
    '{32'h8C220008, 32'h10,       32'd0,        4'd5, 1'b0, 6'd2, 32'hA5000006, 32'd4,     1'b0, 5'd0 },  // R7 lw +
    '{32'h8C22FFF8, 32'h20,       32'd0,        4'd5, 1'b0, 6'd2, 32'hA5000006, 32'd4,     1'b0, 5'd0 },  // R7 lw -
    '{32'h8C220020, 32'h7FFFFFF8, 32'd0,        4'd5, 1'b0, 6'd2, 32'hA5000006, 32'd4,     1'b0, 5'd0 },  // R11 lw ovf addr
    '{32'hAC22FFFC, 32'h20,       32'hDEADBEEF, 4'd4, 1'b1, 6'd7, 32'hDEADBEEF, 32'd4,     1'b0, 5'd0 },  // R8 sw
    '{32'h10220003, 32'd9,        32'd9,        4'd4, 1'b0, 6'd0, 32'd0,        32'd16,    1'b0, 5'd0 },  // R9 taken
    '{32'h10220003, 32'd9,        32'd8,        4'd3, 1'b0, 6'd0, 32'd0,        32'd4,     1'b0, 5'd0 },  // R9 not taken
    '{32'h1022FFFF, 32'd9,        32'd9,        4'd4, 1'b0, 6'd0, 32'd0,        32'd0,     1'b0, 5'd0 },  // R9 backward
    '{32'h10220003, 32'h80000000, 32'd1,        4'd3, 1'b0, 6'd0, 32'd0,        32'd4,     1'b0, 5'd0 },  // R11 beq ovf
    '{32'h08000040, 32'd0,        32'd0,        4'd3, 1'b0, 6'd0, 32'd0,        32'h100,   1'b0, 5'd0 },  // R10 jump
    '{32'hFC000000, 32'd0,        32'd0,        4'd3, 1'b0, 6'd0, 32'd0,        EXC_VEC,   1'b1, 5'd10},  // R5 op 3F
    '{32'h04000000, 32'd0,        32'd0,        4'd3, 1'b0, 6'd0, 32'd0,        EXC_VEC,   1'b1, 5'd10},  // R5 op 01
    '{32'hBC000000, 32'd0,        32'd0,        4'd3, 1'b0, 6'd0, 32'd0,        EXC_VEC,   1'b1, 5'd10}   // R5 op 2F
  };

  function automatic string vreq(input int i);
    case (i)
      0, 3:        return "R3";
      1, 2:        return "R4";
      4, 8, 13:    return "R11";
      5:           return "R6";
      6, 7:        return "R7";
      9:           return "R8";
      10, 11, 12:  return "R9";
      14:          return "R10";
      default:     return "R5";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        ir_wr, mem_rd, mem_wr, reg_wr, reg_dst_rd, wb_mem, epc_wr, cause_wr;
  logic [1:0]  alu_src, alu_op;
  logic [4:0]  pc_sel, cause_code;
  logic        alu_ovf, alu_eq;

  // behavioural datapath
  logic [31:0] pc, ir, ra, rb, alu_out, mdr, epc, opb, res, sx;
  logic [4:0]  cause, dst;
  logic [31:0] rf [32];
  logic [31:0] mem [64];
  logic [31:0] rf_init [32];
  logic [31:0] mem_init [64];
  logic        sel_bad, is_sub, arith;

  mcc_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .alu_ovf(alu_ovf), .alu_eq(alu_eq),
    .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr),
    .reg_dst_rd(reg_dst_rd), .wb_mem(wb_mem), .alu_src(alu_src), .alu_op(alu_op),
    .pc_sel(pc_sel), .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_code(cause_code)
  );

  always_comb begin
    sx = {{16{ir[15]}}, ir[15:0]};
    case (alu_src)
      2'd0:    opb = rb;
      2'd1:    opb = sx;
      default: opb = {16'h0, ir[15:0]};
    endcase
    is_sub = (alu_op == 2'd1) || (alu_op == 2'd3 && ir[5:0] == 6'h22);
    arith  = (alu_op < 2'd2) || (alu_op == 2'd3 && (ir[5:0] == 6'h20 || ir[5:0] == 6'h22));
    case (alu_op)
      2'd0: res = ra + opb;
      2'd1: res = ra - opb;
      2'd2: res = ra | opb;
      default: begin
        case (ir[5:0])
          6'h20:   res = ra + opb;
          6'h22:   res = ra - opb;
          6'h24:   res = ra & opb;
          default: res = ra | opb;
        endcase
      end
    endcase
    alu_ovf = arith && (is_sub ? (ra[31] != opb[31]) : (ra[31] == opb[31])) && (res[31] != ra[31]);
    alu_eq  = (res == 32'd0);
    dst     = reg_dst_rd ? ir[15:11] : ir[20:16];
  end

  always @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0; ir <= 32'd0; epc <= EPC_SENT; cause <= CAU_SENT; sel_bad <= 1'b0;
      for (int k = 0; k < 32; k++) rf[k] <= rf_init[k];
      for (int k = 0; k < 64; k++) mem[k] <= mem_init[k];
    end else begin
      if (ir_wr) ir <= mem[pc[7:2]];
      ra      <= rf[ir[25:21]];
      rb      <= rf[ir[20:16]];
      alu_out <= res;
      mdr     <= mem[alu_out[7:2]];
      if (mem_wr) mem[alu_out[7:2]] <= rb;
      if (reg_wr && dst != 5'd0) rf[dst] <= wb_mem ? mdr : alu_out;
      if (epc_wr) epc <= pc - 32'd4;
      if (cause_wr) cause <= cause_code;
      if (pc_sel[1])      pc <= pc + 32'd4;
      else if (pc_sel[2]) pc <= pc + (sx << 2);
      else if (pc_sel[3]) pc <= {pc[31:28], ir[25:0], 2'b00};
      else if (pc_sel[4]) pc <= EXC_VEC;
      if ($countones(pc_sel) != 1 || epc_wr != cause_wr) sel_bad <= 1'b1;
    end
  end

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_state(input vec_t v);
    for (int k = 0; k < 32; k++) rf_init[k] = (k == 0) ? 32'd0 : (32'h0BAD0000 | k);
    rf_init[1] = v.a_val;
    rf_init[2] = v.b_val;
    for (int k = 0; k < 64; k++) mem_init[k] = 32'hA5000000 | k;
    mem_init[0] = v.instr;
  endtask

  function automatic logic [31:0] fetch_word();
    return {20'd0, ir_wr, mem_rd, mem_wr, reg_wr, epc_wr, cause_wr, 1'b0, pc_sel};
  endfunction

  localparam logic [31:0] FETCH_WORD = {20'd0, 6'b110000, 1'b0, 5'b00010};

  task automatic run_vec(input int i);
    vec_t v;
    string r;
    v = VECS[i];
    r = vreq(i);
    rst = 1'b1;
    load_state(v);
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R2", $sformatf("vec %0d decode outputs", i), {27'd0, ir_wr, pc_sel}, {27'd0, 1'b0, 5'b00001});
    tick(int'(v.cyc) - 2);
    chk(r, $sformatf("vec %0d still busy one cycle early", i), {31'd0, ir_wr}, 32'd0);
    tick(1);
    chk(r, $sformatf("vec %0d back in fetch", i), fetch_word(), FETCH_WORD);
    chk(r, $sformatf("vec %0d pc", i), pc, v.pc);
    if (v.on_mem) chk(r, $sformatf("vec %0d mem[%0d]", i, v.idx), mem[v.idx], v.val);
    else if (v.idx != 6'd0) chk(r, $sformatf("vec %0d r%0d", i, v.idx), rf[v.idx[4:0]], v.val);
    chk(r, $sformatf("vec %0d epc", i), epc, v.exc ? 32'd0 : EPC_SENT);
    chk(r, $sformatf("vec %0d cause", i), {27'd0, cause}, {27'd0, v.exc ? v.cause : CAU_SENT});
    chk("R12", $sformatf("vec %0d pc source and trap pairing", i), {31'd0, sel_bad}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    load_state(VECS[0]);
    tick(3);
    // R1: reset state
    chk("R1", "outputs during reset", fetch_word(), FETCH_WORD);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: reset in the middle of a load
    rst = 1'b1;
    load_state(VECS[6]);
    tick(2);
    rst = 1'b0;
    tick(2);
    chk("R1", "mid-instruction outputs before reset", {31'd0, ir_wr}, 32'd0);
    rst = 1'b1;
    tick(1);
    chk("R1", "outputs after mid-instruction reset", fetch_word(), FETCH_WORD);
    rst = 1'b0;
    tick(5);
    chk("R1", "load completes after mid reset", rf[2], 32'hA5000006);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule